// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of a buffered serial port. It turns their fill levels, the shifter activity and the receive-side access strobes into a five-bit status word and four interrupt sources. The four sources are:

- transmit at or below half full;
- receive at or above half full;
- receive idle timeout;
- receive overrun.

Each source has a raw bit, a mask bit and a masked bit. There is one output line per source and one combined line.

Software sets the mask with a write strobe and data word. The timeout and overrun sources are sticky. Writing one to their clear bits removes them. The transmit and receive sources follow the FIFO levels and cannot be cleared. The FIFO depth and the timeout length are parameters.

Every output is registered from the inputs. A change on the inputs shows on the outputs after the next rising clock edge. Reset is synchronous and active high.

Top module: `sio_irq_status`

## Requirements
- R1: Status bits are busy [4], rx full [3], rx not empty [2], tx not full [1] and tx empty [0]. Full means level equals DEPTH and empty means level 0. Status resets to 0x03 and follows the levels one clock after they are applied.
- R2: Busy (bit 4) is 1 when shift_busy is high or tx_level is non-zero, and 0 otherwise.
- R3: The raw TX bit (bit 3) is 1 whenever tx_level <= DEPTH/2. It resets to 1, so the raw word resets to 0x8.
- R4: The raw RX bit (bit 2) is 1 whenever rx_level >= DEPTH/2.
- R5: The raw timeout bit (bit 1) sets on the bit_tick that ends TIMEOUT_TICKS consecutive ticks since the last rx_pop or rx_push_try. During that span the receive FIFO must be non-empty.
  - Any rx_pop or rx_push_try restarts the count.
  - An empty FIFO holds the count at zero.
  - rx_pop also clears the bit.
- R6: The raw overrun bit (bit 0) sets when rx_push_try is high while rx_level equals DEPTH. It stays set after the FIFO drains.
- R7: Raw, mask and masked words all use bit 3 TX, bit 2 RX, bit 1 timeout and bit 0 overrun.
  - masked_irq = raw_irq AND mask.
  - The mask resets to 0 and loads mask_wdata on mask_we.
- R8: A clr_we with clr_wdata bit 1 set clears the timeout bit. A clr_we with clr_wdata bit 0 set clears the overrun bit. Clear bits 3 and 2 have no effect. A set condition in the same cycle wins over a clear.
- R9: irq_tx, irq_rx, irq_rt and irq_ror equal masked bits 3..0. irq_any is their OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LVL_W | Receive FIFO fill level, 0..DEPTH |
| shift_busy | input | 1 | Serial shifter is moving a frame |
| rx_push_try | input | 1 | Attempt to write the receive FIFO |
| rx_pop | input | 1 | Receive FIFO read strobe |
| bit_tick | input | 1 | One pulse per serial bit period |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 4 | New mask value |
| clr_we | input | 1 | Interrupt clear write strobe |
| clr_wdata | input | 4 | Clear data; bits 1 and 0 act |
| status | output | 5 | Status word |
| raw_irq | output | 4 | Raw interrupt word |
| masked_irq | output | 4 | Masked interrupt word |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_rt | output | 1 | Masked receive timeout interrupt |
| irq_ror | output | 1 | Masked receive overrun interrupt |
| irq_any | output | 1 | OR of the four masked interrupts |

## Verification
The bench drives the level thresholds exactly at DEPTH/2, one below it and one above it. A design with an off-by-one comparison would flip the TX or RX bit at the wrong level.

The timeout is probed one tick before and one tick at the limit. It is also checked after a mid-count read and with an empty FIFO. This catches a counter that fires early, fires late, keeps counting across accesses or fires with nothing to read.

Overrun is checked in four cases:
- a push attempt at one below full, which must not set it;
- after the FIFO drains, where it must stay set;
- against a clear word that sets only the wrong bits;
- against a clear that lands in the same cycle as a new overrun.

Wrong clear decoding or a non-sticky flag shows up in these cases.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int IRQ_W  = 4;
  localparam int IRQ_ROR = 0;
  localparam int IRQ_RT  = 1;
  localparam int IRQ_RX  = 2;
  localparam int IRQ_TX  = 3;

  localparam int STAT_W = 5;
  localparam int ST_TFE = 0;
  localparam int ST_TNF = 1;
  localparam int ST_RNE = 2;
  localparam int ST_RFF = 3;
  localparam int ST_BSY = 4;

  localparam logic [STAT_W-1:0] STAT_RST = 5'h03;
  localparam logic [IRQ_W-1:0]  RAW_RST  = 4'h8;
endpackage

// File: rtl/sio_status_flags.sv
module sio_status_flags
  import sio_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              shift_busy,
  output logic [STAT_W-1:0] status
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [STAT_W-1:0] stat_d;

  always_comb begin
    stat_d         = '0;
    stat_d[ST_TFE] = (tx_level == '0);
    stat_d[ST_TNF] = (tx_level != FULL_LVL);
    stat_d[ST_RNE] = (rx_level != '0);
    stat_d[ST_RFF] = (rx_level == FULL_LVL);
    stat_d[ST_BSY] = shift_busy | (tx_level != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) status <= STAT_RST;
    else     status <= stat_d;
  end
endmodule

// File: rtl/sio_rx_timeout.sv
module sio_rx_timeout #(
  parameter int TIMEOUT_TICKS = 32,
  parameter int LVL_W         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_access,
  input  logic             bit_tick,
  output logic             fire
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TIMEOUT_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             idle_ne;

  assign idle_ne = (rx_level != '0) && !rx_access;
  assign fire    = idle_ne && bit_tick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !idle_ne)                   cnt_q <= '0;
    else if (bit_tick && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio_irq_core.sv
module sio_irq_core
  import sio_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push_try,
  input  logic             rx_pop,
  input  logic             rt_fire,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_wdata,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

  logic [IRQ_W-1:0] raw_d;
  logic             ror_set, ror_clr, rt_clr;
  logic             unused_clr_hi;

  assign unused_clr_hi = ^clr_wdata[IRQ_TX:IRQ_RX];
  assign ror_set = rx_push_try && (rx_level == FULL_LVL);
  assign ror_clr = clr_we && clr_wdata[IRQ_ROR];
  assign rt_clr  = (clr_we && clr_wdata[IRQ_RT]) || rx_pop;

  always_comb begin
    raw_d          = raw_q;
    raw_d[IRQ_TX]  = (tx_level <= HALF_LVL);
    raw_d[IRQ_RX]  = (rx_level >= HALF_LVL);
    if (rt_fire)      raw_d[IRQ_RT] = 1'b1;
    else if (rt_clr)  raw_d[IRQ_RT] = 1'b0;
    if (ror_set)      raw_d[IRQ_ROR] = 1'b1;
    else if (ror_clr) raw_d[IRQ_ROR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= RAW_RST;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_we) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/sio_irq_status.sv
module sio_irq_status
  import sio_irq_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int TIMEOUT_TICKS = 32,
  parameter int LVL_W         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              shift_busy,
  input  logic              rx_push_try,
  input  logic              rx_pop,
  input  logic              bit_tick,
  input  logic              mask_we,
  input  logic [IRQ_W-1:0]  mask_wdata,
  input  logic              clr_we,
  input  logic [IRQ_W-1:0]  clr_wdata,
  output logic [STAT_W-1:0] status,
  output logic [IRQ_W-1:0]  raw_irq,
  output logic [IRQ_W-1:0]  masked_irq,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_rt,
  output logic              irq_ror,
  output logic              irq_any
);
  logic             rt_fire;
  logic [IRQ_W-1:0] mask_q;

  sio_status_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .shift_busy(shift_busy), .status(status)
  );

  sio_rx_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .LVL_W(LVL_W)) u_tmo (
    .clk(clk), .rst(rst), .rx_level(rx_level),
    .rx_access(rx_pop | rx_push_try), .bit_tick(bit_tick), .fire(rt_fire)
  );

  sio_irq_core #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_core (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .rx_push_try(rx_push_try), .rx_pop(rx_pop), .rt_fire(rt_fire),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw_q(raw_irq), .mask_q(mask_q)
  );

  assign masked_irq = raw_irq & mask_q;
  assign irq_tx     = masked_irq[IRQ_TX];
  assign irq_rx     = masked_irq[IRQ_RX];
  assign irq_rt     = masked_irq[IRQ_RT];
  assign irq_ror    = masked_irq[IRQ_ROR];
  assign irq_any    = |masked_irq;
endmodule

// File: rtl/sio_irq_status_chk.sv
module sio_irq_status_chk
  import sio_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_push_try,
  input logic              clr_we,
  input logic [IRQ_W-1:0]  clr_wdata,
  input logic [STAT_W-1:0] status,
  input logic [IRQ_W-1:0]  raw_irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

  a_r1_tx_empty_flag: assert property (@(posedge clk) disable iff (rst)
    (tx_level == '0) |=> status[ST_TFE]);

  a_r3_tx_low_level: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= HALF_LVL) |=> raw_irq[IRQ_TX]);

  a_r6_ror_sets: assert property (@(posedge clk) disable iff (rst)
    (rx_push_try && rx_level == FULL_LVL) |=> raw_irq[IRQ_ROR]);

  a_r6_ror_sticky: assert property (@(posedge clk) disable iff (rst)
    (raw_irq[IRQ_ROR] && !(clr_we && clr_wdata[IRQ_ROR])) |=> raw_irq[IRQ_ROR]);

  a_r8_ror_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_wdata[IRQ_ROR] && !(rx_push_try && rx_level == FULL_LVL))
    |=> !raw_irq[IRQ_ROR]);

  a_r5_no_rt_when_empty: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0 && !raw_irq[IRQ_RT]) |=> !raw_irq[IRQ_RT]);
endmodule

bind sio_irq_status sio_irq_status_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sio_irq_status_tb.sv
module sio_irq_status_tb;
  localparam int DEPTH = 8;
  localparam int TMO   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] tx_level = '0, rx_level = '0;
  logic shift_busy = 0, rx_push_try = 0, rx_pop = 0, bit_tick = 0;
  logic mask_we = 0, clr_we = 0;
  logic [3:0] mask_wdata = '0, clr_wdata = '0;
  logic [4:0] status;
  logic [3:0] raw_irq, masked_irq;
  logic irq_tx, irq_rx, irq_rt, irq_ror, irq_any;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sio_irq_status #(.DEPTH(DEPTH), .TIMEOUT_TICKS(TMO)) u_dut (.*);

  // {tx_level, rx_level, shift_busy, status, raw TX, raw RX}
  localparam logic [15:0] VEC [8] = '{
    {4'd0, 4'd0, 1'b0, 5'h03, 2'b10},
    {4'd0, 4'd0, 1'b1, 5'h13, 2'b10},
    {4'd4, 4'd3, 1'b0, 5'h16, 2'b10},
    {4'd5, 4'd4, 1'b0, 5'h16, 2'b01},
    {4'd8, 4'd8, 1'b0, 5'h1C, 2'b01},
    {4'd1, 4'd7, 1'b1, 5'h16, 2'b11},
    {4'd0, 4'd1, 1'b0, 5'h07, 2'b10},
    {4'd8, 4'd0, 1'b0, 5'h10, 2'b00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    chk("R1 reset status", {3'b0, status}, 8'h03);
    chk("R3 reset raw", {4'b0, raw_irq}, 8'h08);
    chk("R7 reset masked", {4'b0, masked_irq}, 8'h00);
    chk("R9 reset any", {7'b0, irq_any}, 8'h00);

    mask_we = 1; mask_wdata = 4'hF; step(); mask_we = 0;

    for (int i = 0; i < 8; i++) begin
      tx_level = VEC[i][15:12];
      rx_level = VEC[i][11:8];
      shift_busy = VEC[i][7];
      step();
      chk($sformatf("R1 R2 status vec%0d", i), {3'b0, status}, {3'b0, VEC[i][6:2]});
      chk($sformatf("R3 R4 raw vec%0d", i), {6'b0, raw_irq[3:2]}, {6'b0, VEC[i][1:0]});
      chk($sformatf("R9 lines vec%0d", i), {5'b0, irq_tx, irq_rx, irq_any},
          {5'b0, VEC[i][1], VEC[i][0], |VEC[i][1:0]});
    end

    // R7: mask cleared gates a pending raw TX
    tx_level = 0; rx_level = 0; shift_busy = 0;
    mask_we = 1; mask_wdata = 4'h0; step(); mask_we = 0;
    chk("R7 raw kept", {7'b0, raw_irq[3]}, 8'h01);
    chk("R7 masked zero", {4'b0, masked_irq}, 8'h00);
    chk("R9 any masked off", {7'b0, irq_any}, 8'h00);
    mask_we = 1; mask_wdata = 4'h1; step(); mask_we = 0;

    // R6: overrun
    rx_level = 7; rx_push_try = 1; step(); rx_push_try = 0;
    chk("R6 no ror below full", {7'b0, raw_irq[0]}, 8'h00);
    rx_level = 8; rx_push_try = 1; step(); rx_push_try = 0;
    chk("R6 ror set", {7'b0, raw_irq[0]}, 8'h01);
    chk("R9 ror line", {6'b0, irq_ror, irq_any}, 8'h03);
    rx_level = 0; step(); step();
    chk("R6 ror sticky after drain", {7'b0, raw_irq[0]}, 8'h01);
    clr_we = 1; clr_wdata = 4'b1110; step(); clr_we = 0;
    chk("R8 wrong clear bits", {7'b0, raw_irq[0]}, 8'h01);
    chk("R8 tx not clearable", {7'b0, raw_irq[3]}, 8'h01);
    clr_we = 1; clr_wdata = 4'b0001; step(); clr_we = 0;
    chk("R8 ror cleared", {7'b0, raw_irq[0]}, 8'h00);
    rx_level = 8; rx_push_try = 1; clr_we = 1; clr_wdata = 4'b0001; step();
    rx_push_try = 0; clr_we = 0;
    chk("R8 set wins over clear", {7'b0, raw_irq[0]}, 8'h01);
    clr_we = 1; clr_wdata = 4'b0001; rx_level = 0; step(); clr_we = 0;

    // R5: receive timeout
    mask_we = 1; mask_wdata = 4'h2; step(); mask_we = 0;
    rx_level = 1; rx_pop = 1; step(); rx_pop = 0;
    bit_tick = 1;
    repeat (TMO - 1) step();
    chk("R5 no timeout one tick early", {7'b0, raw_irq[1]}, 8'h00);
    step();
    chk("R5 timeout at limit", {6'b0, raw_irq[1], irq_rt}, 8'h03);
    clr_we = 1; clr_wdata = 4'b0010; step(); clr_we = 0;
    chk("R8 rt cleared", {7'b0, raw_irq[1]}, 8'h00);
    repeat (5) step();
    chk("R5 no refire while saturated", {7'b0, raw_irq[1]}, 8'h00);
    rx_pop = 1; step(); rx_pop = 0;
    repeat (20) step();
    rx_pop = 1; step(); rx_pop = 0;
    repeat (TMO - 1) step();
    chk("R5 count restarted by read", {7'b0, raw_irq[1]}, 8'h00);
    step();
    chk("R5 timeout after restart", {7'b0, raw_irq[1]}, 8'h01);
    rx_pop = 1; step(); rx_pop = 0;
    chk("R5 read clears rt", {7'b0, raw_irq[1]}, 8'h00);
    rx_level = 0;
    repeat (TMO + 8) step();
    chk("R5 empty never times out", {7'b0, raw_irq[1]}, 8'h00);
    bit_tick = 0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule